// File: doc/BRIEF.md
# Extended Banked Memory Mapper

This block sits between an 8-bit processor with a 16-bit address bus and a one-megabyte memory built as sixteen 64K blocks. For each processor access it produces a 4-bit physical block number and a translated high address byte. The processor's low address byte passes around the block untouched. The mapping comes from a small register file that the processor writes through a narrow register port. That file holds a configuration register, a RAM-control register, two relocation pointers (one for page 0 and one for page 1) and a video extension register. A separate 4-bit block number is produced for video and DMA fetches.

The block number is made of two 2-bit fields. The RAM-control register supplies the upper pair, which chooses a 256K group. The configuration register supplies the lower pair, which chooses a 64K block inside that group. A common-memory window at the bottom, the top or both ends of the address space always lands in block 0. Page 0 and page 1 can each be relocated to any page of any block. The relocated page and the page it was swapped with both take precedence over the common window, so a zero page moved into a nonzero block keeps working while bottom common RAM is enabled. The translation is purely combinational: a new register value governs translation from the clock edge that stores it.

Top module: `xmap_top`

## Requirements
- R1: After reset every register reads back 0x00, and an access that is not relocated and not in a common window yields block 0 and an unchanged high byte. The video block is 0.
- R2: Bits 7:6 of the configuration register (offset 0) drive physBlock[1:0] for an ordinary access, and physHigh equals cpuHigh.
- R3: Bits 5:4 of the RAM-control register (offset 1) drive physBlock[3:2] for an ordinary access.
- R4: RAM-control bits 1:0 give the common size (0=1K, 1=4K, 2=8K, 3=16K, i.e. 4, 16, 32 or 64 pages). Bits 3:2 give the placement (0=none, 1=bottom, 2=top, 3=both). An access in the window yields block 0 and an unchanged high byte.
- R5: Pointer n (n=0 at offsets 2/3, n=1 at offsets 4/5) is active when its committed target page or block is nonzero. The low byte is the target page; bits 3:0 of the high byte are the target block. An access to page n with pointer n active yields that block and page. Page 0 is tested before page 1.
- R6: A write to a pointer's low byte is staged and changes no translation until its high byte is written. At that point the staged page and the new block are committed together. The low offset reads back the staged value.
- R7: With pointer n active, an access to its target page while the selected block equals its target block yields block 0, page n. Pointer 0 is tested first.
- R8: Relocation, in either direction, takes precedence over the common window.
- R9: The video block is {bits 1:0 of the video extension register (offset 6), bits 7:6 of the RAM-control register}.
- R10: Each mapped offset reads back the last byte written to it. Offsets 7 to 15 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, sampled at the rising edge |
| regAddr | input | 4 | Register offset for reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |
| cpuHigh | input | 8 | Processor address bits 15:8 |
| physBlock | output | 4 | Physical 64K block for the processor access |
| physHigh | output | 8 | Translated address bits 15:8 |
| vidBlock | output | 4 | Physical block for video/DMA fetches |

## Verification
The outputs are combinational from the stored registers, so a wrong register state shows at the ports on the first access that depends on it, in the cycle right after the faulty write. A lost or early pointer commit appears as a wrong block or page on the next page-0/page-1 access, or on the next access to the swapped-in target. A corrupted field surfaces as a wrong block in one of the four address classes (relocated, swapped back, common, ordinary), or as a wrong read-back at that register's offset. The bench therefore steers addresses toward page 0, page 1, the live pointer targets and the window edges on every clock.

// File: rtl/xmap_pkg.sv
package xmap_pkg;
  localparam int DATA_W  = 8;
  localparam int PAGE_W  = 8;
  localparam int BLK_W   = 4;
  localparam int FIELD_W = 2;
  localparam int REG_AW  = 4;
  localparam int NUM_PTR = 2;

  localparam logic [REG_AW-1:0] OFS_CFG      = 4'd0;
  localparam logic [REG_AW-1:0] OFS_RAMCTL   = 4'd1;
  localparam logic [REG_AW-1:0] OFS_PTR_BASE = 4'd2;
  localparam logic [REG_AW-1:0] OFS_VIDX     = 4'd6;

  typedef struct packed {
    logic               cfgWe;
    logic               ctlWe;
    logic               vidWe;
    logic [NUM_PTR-1:0] loWe;
    logic [NUM_PTR-1:0] hiWe;
  } regStrobe_t;

  typedef enum logic [2:0] {
    RD_CFG, RD_CTL, RD_LO0, RD_HI0, RD_LO1, RD_HI1, RD_VIDX, RD_NONE
  } rdSel_t;
endpackage

// File: rtl/xmap_ctrl.sv
module xmap_ctrl
  import xmap_pkg::*;
(
  input  logic              wrEn,
  input  logic [REG_AW-1:0] addr,
  output regStrobe_t        stb,
  output rdSel_t            rdSel
);
  logic [NUM_PTR-1:0] loHit;
  logic [NUM_PTR-1:0] hiHit;

  for (genvar i = 0; i < NUM_PTR; i++) begin : gPtrDec
    localparam logic [REG_AW-1:0] LO_OFS = OFS_PTR_BASE + REG_AW'(2 * i);
    localparam logic [REG_AW-1:0] HI_OFS = LO_OFS + REG_AW'(1);
    assign loHit[i] = (addr == LO_OFS);
    assign hiHit[i] = (addr == HI_OFS);
  end

  always_comb begin
    stb.cfgWe = wrEn && (addr == OFS_CFG);
    stb.ctlWe = wrEn && (addr == OFS_RAMCTL);
    stb.vidWe = wrEn && (addr == OFS_VIDX);
    stb.loWe  = loHit & {NUM_PTR{wrEn}};
    stb.hiWe  = hiHit & {NUM_PTR{wrEn}};
  end

  always_comb begin
    if (addr == OFS_CFG)         rdSel = RD_CFG;
    else if (addr == OFS_RAMCTL) rdSel = RD_CTL;
    else if (loHit[0])           rdSel = RD_LO0;
    else if (hiHit[0])           rdSel = RD_HI0;
    else if (loHit[1])           rdSel = RD_LO1;
    else if (hiHit[1])           rdSel = RD_HI1;
    else if (addr == OFS_VIDX)   rdSel = RD_VIDX;
    else                         rdSel = RD_NONE;
  end
endmodule

// File: rtl/xmap_regs.sv
module xmap_regs
  import xmap_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  regStrobe_t                          stb,
  input  rdSel_t                              rdSel,
  input  logic [DATA_W-1:0]                   wrData,
  output logic [DATA_W-1:0]                   rdData,
  output logic [FIELD_W-1:0]                  cfgBank,
  output logic [FIELD_W-1:0]                  superBank,
  output logic [FIELD_W-1:0]                  commonSize,
  output logic [FIELD_W-1:0]                  commonPlace,
  output logic [BLK_W-1:0]                    vidBlock,
  output logic [NUM_PTR-1:0][PAGE_W-1:0]      relPage,
  output logic [NUM_PTR-1:0][BLK_W-1:0]       relBlk
);
  logic [DATA_W-1:0] cfgQ, ctlQ, vidxQ;
  logic [NUM_PTR-1:0][DATA_W-1:0] stageW, hiW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      ctlQ  <= '0;
      vidxQ <= '0;
    end else begin
      if (stb.cfgWe) cfgQ  <= wrData;
      if (stb.ctlWe) ctlQ  <= wrData;
      if (stb.vidWe) vidxQ <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : gPtr
    logic [DATA_W-1:0] stageQ, hiQ;
    logic [PAGE_W-1:0] pageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ <= '0;
        hiQ    <= '0;
        pageQ  <= '0;
      end else begin
        if (stb.loWe[i]) stageQ <= wrData;
        if (stb.hiWe[i]) begin
          hiQ   <= wrData;
          pageQ <= stageQ;
        end
      end
    end
    assign stageW[i]  = stageQ;
    assign hiW[i]     = hiQ;
    assign relPage[i] = pageQ;
    assign relBlk[i]  = hiQ[BLK_W-1:0];
  end

  assign cfgBank     = cfgQ[7:6];
  assign superBank   = ctlQ[5:4];
  assign commonPlace = ctlQ[3:2];
  assign commonSize  = ctlQ[1:0];
  assign vidBlock    = {vidxQ[1:0], ctlQ[7:6]};

  always_comb begin
    unique case (rdSel)
      RD_CFG:  rdData = cfgQ;
      RD_CTL:  rdData = ctlQ;
      RD_LO0:  rdData = stageW[0];
      RD_HI0:  rdData = hiW[0];
      RD_LO1:  rdData = stageW[1];
      RD_HI1:  rdData = hiW[1];
      RD_VIDX: rdData = vidxQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/xmap_xlate.sv
module xmap_xlate
  import xmap_pkg::*;
(
  input  logic [PAGE_W-1:0]              cpuHigh,
  input  logic [FIELD_W-1:0]             cfgBank,
  input  logic [FIELD_W-1:0]             superBank,
  input  logic [FIELD_W-1:0]             commonSize,
  input  logic [FIELD_W-1:0]             commonPlace,
  input  logic [NUM_PTR-1:0][PAGE_W-1:0] relPage,
  input  logic [NUM_PTR-1:0][BLK_W-1:0]  relBlk,
  output logic [BLK_W-1:0]               physBlock,
  output logic [PAGE_W-1:0]              physHigh
);
  localparam int SPAN_W = PAGE_W + 1;
  localparam logic [SPAN_W-1:0] PAGE_SPAN = SPAN_W'(1) << PAGE_W;

  logic [BLK_W-1:0]   normBlk;
  logic [SPAN_W-1:0]  winPages;
  logic [SPAN_W-1:0]  pageExt;
  logic               inCommon;
  logic [NUM_PTR-1:0] ptrLive, fwdHit, revHit;

  assign normBlk = {superBank, cfgBank};
  assign pageExt = {1'b0, cpuHigh};

  always_comb begin
    unique case (commonSize)
      2'd0:    winPages = SPAN_W'(4);
      2'd1:    winPages = SPAN_W'(16);
      2'd2:    winPages = SPAN_W'(32);
      default: winPages = SPAN_W'(64);
    endcase
    inCommon = (commonPlace[0] && (pageExt < winPages)) ||
               (commonPlace[1] && (pageExt >= (PAGE_SPAN - winPages)));
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : gMatch
    assign ptrLive[i] = (relPage[i] != '0) || (relBlk[i] != '0);
    assign fwdHit[i]  = ptrLive[i] && (cpuHigh == PAGE_W'(i));
    assign revHit[i]  = ptrLive[i] && (cpuHigh == relPage[i]) && (normBlk == relBlk[i]);
  end

  always_comb begin
    physBlock = normBlk;
    physHigh  = cpuHigh;
    if (inCommon) physBlock = '0;
    for (int i = NUM_PTR - 1; i >= 0; i--) begin
      if (revHit[i]) begin
        physBlock = '0;
        physHigh  = PAGE_W'(i);
      end
    end
    for (int i = NUM_PTR - 1; i >= 0; i--) begin
      if (fwdHit[i]) begin
        physBlock = relBlk[i];
        physHigh  = relPage[i];
      end
    end
  end
endmodule

// File: rtl/xmap_top.sv
module xmap_top
  import xmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [PAGE_W-1:0] cpuHigh,
  output logic [BLK_W-1:0]  physBlock,
  output logic [PAGE_W-1:0] physHigh,
  output logic [BLK_W-1:0]  vidBlock
);
  regStrobe_t stb;
  rdSel_t     rdSel;
  logic [FIELD_W-1:0] cfgBank, superBank, commonSize, commonPlace;
  logic [NUM_PTR-1:0][PAGE_W-1:0] relPage;
  logic [NUM_PTR-1:0][BLK_W-1:0]  relBlk;

  xmap_ctrl u_ctrl (
    .wrEn (regWrEn),
    .addr (regAddr),
    .stb  (stb),
    .rdSel(rdSel)
  );

  xmap_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .wrData     (regWrData),
    .rdData     (regRdData),
    .cfgBank    (cfgBank),
    .superBank  (superBank),
    .commonSize (commonSize),
    .commonPlace(commonPlace),
    .vidBlock   (vidBlock),
    .relPage    (relPage),
    .relBlk     (relBlk)
  );

  xmap_xlate u_xlate (
    .cpuHigh    (cpuHigh),
    .cfgBank    (cfgBank),
    .superBank  (superBank),
    .commonSize (commonSize),
    .commonPlace(commonPlace),
    .relPage    (relPage),
    .relBlk     (relBlk),
    .physBlock  (physBlock),
    .physHigh   (physHigh)
  );
endmodule

// File: rtl/xmap_checks.sv
module xmap_checks
  import xmap_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           regWrEn,
  input logic [REG_AW-1:0]              regAddr,
  input logic [DATA_W-1:0]              regWrData,
  input logic [DATA_W-1:0]              regRdData,
  input logic [PAGE_W-1:0]              cpuHigh,
  input logic [BLK_W-1:0]               physBlock,
  input logic [PAGE_W-1:0]              physHigh,
  input logic [BLK_W-1:0]               vidBlock,
  input logic [FIELD_W-1:0]             cfgBank,
  input logic [FIELD_W-1:0]             superBank,
  input logic [FIELD_W-1:0]             commonPlace,
  input logic [NUM_PTR-1:0][PAGE_W-1:0] relPage
);
  logic notTarget;
  assign notTarget = (cpuHigh != relPage[0]) && (cpuHigh != relPage[1]);

  // R2 R3: ordinary access with no common window uses the selected block
  assert_plain_block_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHigh > 8'd1 && commonPlace == 2'd0 && notTarget)
      |-> (physBlock == {superBank, cfgBank} && physHigh == cpuHigh));

  // R4: pages 2 and 3 lie inside every bottom window
  assert_common_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHigh > 8'd1 && cpuHigh < 8'd4 && commonPlace[0] && notTarget)
      |-> (physBlock == '0 && physHigh == cpuHigh));

  // R5: committing pointer 0 retargets page 0 to the written block
  assert_ptr_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_PTR_BASE + 4'd1)
      |=> (cpuHigh != 8'h00 || physBlock == $past(regWrData[BLK_W-1:0]) || $past(regWrData[BLK_W-1:0]) == '0));

  // R6: a low-byte write alone leaves the page-0 translation unchanged
  assert_stage_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_PTR_BASE && cpuHigh == 8'h00)
      |=> (cpuHigh != 8'h00 || $stable(physHigh)));

  // R9: video block low bits follow RAM-control bits 7:6
  assert_video_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_RAMCTL)
      |=> (vidBlock[1:0] == $past(regWrData[7:6])));

  // R10: mapped offsets read back the last written byte
  assert_readback_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr <= OFS_VIDX)
      |=> (regAddr != $past(regAddr) || regRdData == $past(regWrData)));

  // R10: unmapped offsets read zero
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > OFS_VIDX) |-> (regRdData == '0));
endmodule

bind xmap_top xmap_checks u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .cpuHigh    (cpuHigh),
  .physBlock  (physBlock),
  .physHigh   (physHigh),
  .vidBlock   (vidBlock),
  .cfgBank    (cfgBank),
  .superBank  (superBank),
  .commonPlace(commonPlace),
  .relPage    (relPage)
);

// File: tb/sim_xmap_top.sv
module sim_xmap_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 4000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] cpuHigh = '0;
  logic [3:0] physBlock;
  logic [7:0] physHigh;
  logic [3:0] vidBlock;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural register image
  logic [7:0] mCfg = 0, mCtl = 0, mVid = 0;
  logic [7:0] mStage [2] = '{0, 0};
  logic [7:0] mHi [2] = '{0, 0};
  logic [7:0] mPage [2] = '{0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  xmap_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cpuHigh(cpuHigh),
    .physBlock(physBlock), .physHigh(physHigh), .vidBlock(vidBlock)
  );

  function automatic logic [7:0] modelRead(input logic [3:0] a);
    case (a)
      4'd0: return mCfg;
      4'd1: return mCtl;
      4'd2: return mStage[0];
      4'd3: return mHi[0];
      4'd4: return mStage[1];
      4'd5: return mHi[1];
      4'd6: return mVid;
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelXlate(input logic [7:0] pg, output logic [3:0] b,
                            output logic [7:0] h, output string tag);
    int winSz;
    int p;
    bit inWin;
    logic [3:0] sel;
    sel = {mCtl[5:4], mCfg[7:6]};
    p = pg;
    case (mCtl[1:0])
      2'd0: winSz = 4;
      2'd1: winSz = 16;
      2'd2: winSz = 32;
      default: winSz = 64;
    endcase
    inWin = (mCtl[2] && p < winSz) || (mCtl[3] && p >= 256 - winSz);
    b = sel; h = pg; tag = "R2 R3";
    if (inWin) begin b = 4'd0; tag = "R4"; end
    // reverse direction: pointer 1 first so pointer 0 wins
    for (int i = 1; i >= 0; i--) begin
      if ((mPage[i] != 0 || mHi[i][3:0] != 0) && pg == mPage[i] && sel == mHi[i][3:0]) begin
        b = 4'd0; h = 8'(i); tag = inWin ? "R7 R8" : "R7";
      end
    end
    for (int i = 1; i >= 0; i--) begin
      if ((mPage[i] != 0 || mHi[i][3:0] != 0) && p == i) begin
        b = mHi[i][3:0]; h = mPage[i]; tag = inWin ? "R5 R8" : "R5";
      end
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [7:0] d, input logic [7:0] pg);
    logic [3:0] eb;
    logic [7:0] eh;
    string tag;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; cpuHigh = pg;
    #1;
    modelXlate(pg, eb, eh, tag);
    if (!rstN) tag = "R1";
    check(tag, "physBlock", int'(physBlock), int'(eb));
    check(tag, "physHigh", int'(physHigh), int'(eh));
    check(rstN ? "R9" : "R1", "vidBlock", int'(vidBlock), int'({mVid[1:0], mCtl[7:6]}));
    check(rstN ? ((a == 4'd2 || a == 4'd4) ? "R6" : "R10") : "R1", "regRdData",
          int'(regRdData), int'(modelRead(a)));
    @(posedge clk);
    #1;
    if (we && rstN) begin
      case (a)
        4'd0: mCfg = d;
        4'd1: mCtl = d;
        4'd2: mStage[0] = d;
        4'd3: begin mHi[0] = d; mPage[0] = mStage[0]; end
        4'd4: mStage[1] = d;
        4'd5: begin mHi[1] = d; mPage[1] = mStage[1]; end
        4'd6: mVid = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d, 8'h42);
  endtask

  task automatic look(input logic [3:0] a, input logic [7:0] pg);
    step(1'b0, a, 8'h00, pg);
  endtask

  initial begin
    // R1: register and output state while and after reset
    for (int a = 0; a < 16; a++) step(1'b0, 4'(a), 8'h00, 8'(a * 17));
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) look(4'(a), 8'(a));
    // R2: configuration bits pick the block inside the group
    wr(4'd0, 8'hC0); look(4'd0, 8'h40); look(4'd0, 8'hFF);
    // R3: super-bank bits
    wr(4'd1, 8'h30); look(4'd1, 8'h40);
    wr(4'd0, 8'h40); look(4'd1, 8'h00);
    // R4: bottom 4K window, then top 16K window, then both 1K
    wr(4'd1, 8'h35); look(4'd1, 8'h0F); look(4'd1, 8'h10);
    wr(4'd1, 8'h3B); look(4'd1, 8'hC0); look(4'd1, 8'hBF);
    wr(4'd1, 8'h3C); look(4'd1, 8'h03); look(4'd1, 8'hFC); look(4'd1, 8'hFB); look(4'd1, 8'h04);
    // R6: staged low byte has no effect until the high byte
    wr(4'd1, 8'h10); wr(4'd0, 8'h40);
    wr(4'd2, 8'h80); look(4'd2, 8'h00); look(4'd2, 8'h80);
    wr(4'd3, 8'h05); look(4'd3, 8'h00);
    // R7: target page in the selected block swaps back to page 0
    look(4'd3, 8'h80); wr(4'd0, 8'h80); look(4'd3, 8'h80);
    // R8: bottom 16K common with page 1 moved into block 9
    wr(4'd4, 8'h20); wr(4'd5, 8'h09); wr(4'd1, 8'h27); wr(4'd0, 8'h40);
    look(4'd5, 8'h01); look(4'd5, 8'h20); look(4'd4, 8'h21);
    // R5: page 0 tested before page 1 reverse match
    wr(4'd2, 8'h01); wr(4'd3, 8'h09); look(4'd3, 8'h00); look(4'd3, 8'h01);
    // R9: video block
    wr(4'd1, 8'hC0); wr(4'd6, 8'h02); look(4'd6, 8'h00);
    // R10: unmapped offsets ignore writes
    wr(4'd9, 8'hFF); look(4'd9, 8'h00); wr(4'd15, 8'hAA); look(4'd15, 8'h00);
    for (int a = 0; a < 7; a++) look(4'(a), 8'h33);
    // mixed traffic
    for (int n = 0; n < RAND_STEPS; n++) begin
      logic [7:0] pg;
      logic [3:0] a;
      case ($urandom % 7)
        0: pg = 8'h00;
        1: pg = 8'h01;
        2: pg = mPage[0];
        3: pg = mPage[1];
        4: pg = 8'($urandom % 8);
        5: pg = 8'hC0 + 8'($urandom % 64);
        default: pg = 8'($urandom);
      endcase
      a = ($urandom % 10 == 0) ? 4'($urandom) : 4'($urandom % 7);
      step(($urandom % 3) == 0, a, 8'($urandom), pg);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule